// File: doc/BRIEF.md
# Bit-Serial Symmetric FIR Tap Slice

This block is one tap of a finite impulse response filter whose coefficients are symmetric. Two data samples that share a weight arrive as bit-serial two's complement words, least significant bit first. The slice adds them with a serial pre-adder, multiplies the sum by a 10-bit weight, and returns the product on one serial pin, least significant bit first. The product is truncated to the data word length. A word-mark strobe travels with the data so that the stages further down stay aligned. Sixteen such slices feeding an adder tree give a 32-tap filter.

The word length `DATA_W` is a parameter, and one word occupies that many bit times. The weight for a word is shifted in on its own serial pin during the first ten bit times of the same word. Its binary point lies after the second bit, which gives a range of -2 to 2 - 2^-8. Every data and weight pin is negative-true. A pin that is left high therefore carries a numeric zero. Inside the slice, the serial stream is gathered into a word. The multiplier then consumes one weight bit per bit time with shift-and-add steps, and the result is shifted out again. No parallel multiplier is built.

Top module: `symfir_tap_slice`

## Requirements
- R1: After reset, `prod_n` reads 1 (numeric zero) and `word_mark_out` reads 0. The first two output words after the first `word_mark_in` are numeric zero.
- R2: All data and weight pins are negative-true: a pin level of 1 means bit value 0. With all three serial input pins held high, every output word is numeric zero.
- R3: The pre-adder forms A+B over the DATA_W bits of each word. Its carry is cleared in the cycle in which `word_mark_in` is high, so no carry passes from one word into the next. Each input sample keeps its top three bits equal.
- R4: For a sum S and a weight C, the output word equals bits [DATA_W+7:8] of the full product S*C, with C taken as a 10-bit two's complement integer. This is floor(S*C/256) reduced to DATA_W bits.
- R5: Negative sums, negative weights, the largest weight (511, meaning 2 - 2^-8) and the most negative weight (-512, meaning -2) all give the R4 result.
- R6: The weight is the first ten bits of the `wgt_n` stream in each word, sent LSB first. Weight pin bits at positions 10 to DATA_W-1 of a word have no effect on the product.
- R7: The product of the word whose mark is in cycle t begins, LSB first, on `prod_n` in cycle t + 2*DATA_W + 1. `word_mark_out` is high in exactly that cycle, which is one cycle after each `word_mark_in`.
- R8: Once the first mark has been seen, words follow back to back with `word_mark_in` high every DATA_W cycles. Each word's weight multiply completes before the next word is loaded. Every word in an unbroken stream gets its own correct product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| word_mark_in | input | 1 | High during the LSB bit time of the input words |
| pair_lo_n | input | 1 | First sample of the symmetric pair, negative-true serial |
| pair_hi_n | input | 1 | Second sample of the symmetric pair, negative-true serial |
| wgt_n | input | 1 | Weight bits, negative-true serial, first ten bit times of each word |
| prod_n | output | 1 | Truncated product, negative-true serial, LSB first |
| word_mark_out | output | 1 | High during the LSB bit time of `prod_n` |

## Verification
The bench builds the slice with DATA_W of 12, a 10-bit weight and 8 fraction bits. At this length the ten multiply steps leave a single spare bit time before the next word loads, so the timing margin is at its narrowest. The two weight-pin bits beyond the tenth position also exist to be toggled. Data samples stay small at this width, which makes the extremes reachable: pairs of -512, a sum of -1024, a weight of -2 and the largest positive weight. A scoreboard compares every output word across a back-to-back stream, including a carry-out word followed by a zero word.

// File: rtl/symfir_pkg.sv
`timescale 1ns/1ps
package symfir_pkg;

    localparam int WGT_W_DEF    = 10;
    localparam int WGT_FRAC_DEF = 8;

    // Decoded (positive-true) serial bits of one bit time
    typedef struct packed {
        logic lo;
        logic hi;
        logic wgt;
    } tap_bits_t;

    // Result of a one-bit full adder
    typedef struct packed {
        logic cout;
        logic sum;
    } fa_t;

    typedef enum logic {
        MUL_RUN  = 1'b0,
        MUL_IDLE = 1'b1
    } mul_state_e;

    function automatic fa_t full_add(input logic x, input logic y, input logic cin);
        fa_t r;
        r.sum  = x ^ y ^ cin;
        r.cout = (x & y) | (x & cin) | (y & cin);
        return r;
    endfunction

endpackage

// File: rtl/symfir_phase.sv
`timescale 1ns/1ps
module symfir_phase #(
    parameter int DATA_W = 16,
    parameter int WGT_W  = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic mark,
    output logic wgt_en,
    output logic seen
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] WGT_END = CNT_W'(WGT_W);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pos;
    logic             seen_q;

    always_comb pos = mark ? '0 : cnt_q;
    assign wgt_en = (pos < WGT_END);
    assign seen   = seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= CNT_TOP;
            seen_q <= 1'b0;
        end else begin
            cnt_q  <= (pos == CNT_TOP) ? CNT_TOP : pos + 1'b1;
            seen_q <= seen_q | mark;
        end
    end

    // R8
    period_chk: assert property (@(posedge clk) disable iff (rst)
        seen_q |-> (mark == (cnt_q == CNT_TOP)));

endmodule

// File: rtl/symfir_preadd.sv
`timescale 1ns/1ps
module symfir_preadd
    import symfir_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mark,
    input  logic              seen,
    input  logic              lo_bit,
    input  logic              hi_bit,
    output logic [DATA_W-1:0] sum_word
);
    logic              carry_q;
    logic [DATA_W-1:0] sum_sr;
    fa_t               fa;

    // carry restarts at the LSB of every word
    always_comb fa = full_add(lo_bit, hi_bit, mark ? 1'b0 : carry_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q <= 1'b0;
            sum_sr  <= '0;
        end else begin
            carry_q <= fa.cout;
            sum_sr  <= {fa.sum, sum_sr[DATA_W-1:1]};
        end
    end

    assign sum_word = sum_sr;

    // R3
    headroom_chk: assert property (@(posedge clk) disable iff (rst)
        (mark && seen) |-> (sum_sr[DATA_W-1] == sum_sr[DATA_W-2]));

endmodule

// File: rtl/symfir_mult.sv
`timescale 1ns/1ps
module symfir_mult
    import symfir_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int WGT_W    = 10,
    parameter int WGT_FRAC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              wgt_en,
    input  logic              wgt_bit,
    input  logic [DATA_W-1:0] sum_word,
    output logic [DATA_W-1:0] prod_word
);
    localparam int PROD_W = DATA_W + WGT_W;
    localparam int STEP_W = $clog2(WGT_W + 1);
    localparam logic [STEP_W-1:0] STEP_END  = STEP_W'(WGT_W);
    localparam logic [STEP_W-1:0] STEP_SIGN = STEP_W'(WGT_W - 1);

    logic [WGT_W-1:0]  wgt_sr;
    logic [WGT_W-1:0]  wgt_op;
    logic [PROD_W-1:0] mcand;
    logic [PROD_W-1:0] acc;
    logic [PROD_W-1:0] acc_next;
    logic [STEP_W-1:0] step_q;
    mul_state_e        state;

    always_comb state = (step_q == STEP_END) ? MUL_IDLE : MUL_RUN;

    // the top weight bit carries negative weight
    always_comb begin
        acc_next = acc;
        if (wgt_op[0]) begin
            if (step_q == STEP_SIGN) acc_next = acc - mcand;
            else                     acc_next = acc + mcand;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wgt_sr <= '0;
            wgt_op <= '0;
            mcand  <= '0;
            acc    <= '0;
            step_q <= STEP_END;
        end else begin
            if (wgt_en) wgt_sr <= {wgt_bit, wgt_sr[WGT_W-1:1]};
            if (load) begin
                wgt_op <= wgt_sr;
                mcand  <= {{WGT_W{sum_word[DATA_W-1]}}, sum_word};
                acc    <= '0;
                step_q <= '0;
            end else if (state == MUL_RUN) begin
                acc    <= acc_next;
                mcand  <= {mcand[PROD_W-2:0], 1'b0};
                wgt_op <= {1'b0, wgt_op[WGT_W-1:1]};
                step_q <= step_q + 1'b1;
            end
        end
    end

    assign prod_word = acc[WGT_FRAC +: DATA_W];

    // R8
    mult_done_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> (state == MUL_IDLE));

    // R6
    wgt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wgt_en |=> $stable(wgt_sr));

endmodule

// File: rtl/symfir_serout.sv
`timescale 1ns/1ps
module symfir_serout #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] prod_word,
    output logic              bit_out,
    output logic              mark_out
);
    logic [DATA_W-1:0] out_sr;
    logic              mark_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_sr <= '0;
            mark_q <= 1'b0;
        end else begin
            out_sr <= load ? prod_word : {1'b0, out_sr[DATA_W-1:1]};
            mark_q <= load;
        end
    end

    assign bit_out  = out_sr[0];
    assign mark_out = mark_q;

    // R7
    mark_bit0_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (bit_out == $past(prod_word[0])));

endmodule

// File: rtl/symfir_tap_slice.sv
`timescale 1ns/1ps
module symfir_tap_slice
    import symfir_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int WGT_W    = WGT_W_DEF,
    parameter int WGT_FRAC = WGT_FRAC_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic word_mark_in,
    input  logic pair_lo_n,
    input  logic pair_hi_n,
    input  logic wgt_n,
    output logic prod_n,
    output logic word_mark_out
);
    tap_bits_t         pin;
    logic              wgt_en;
    logic              seen;
    logic [DATA_W-1:0] sum_word;
    logic [DATA_W-1:0] prod_word;
    logic              prod_bit;

    // negative-true pins: a high level is a zero bit
    always_comb begin
        pin.lo  = ~pair_lo_n;
        pin.hi  = ~pair_hi_n;
        pin.wgt = ~wgt_n;
    end

    symfir_phase #(.DATA_W(DATA_W), .WGT_W(WGT_W)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .mark   (word_mark_in),
        .wgt_en (wgt_en),
        .seen   (seen)
    );

    symfir_preadd #(.DATA_W(DATA_W)) u_preadd (
        .clk      (clk),
        .rst      (rst),
        .mark     (word_mark_in),
        .seen     (seen),
        .lo_bit   (pin.lo),
        .hi_bit   (pin.hi),
        .sum_word (sum_word)
    );

    symfir_mult #(.DATA_W(DATA_W), .WGT_W(WGT_W), .WGT_FRAC(WGT_FRAC)) u_mult (
        .clk       (clk),
        .rst       (rst),
        .load      (word_mark_in),
        .wgt_en    (wgt_en),
        .wgt_bit   (pin.wgt),
        .sum_word  (sum_word),
        .prod_word (prod_word)
    );

    symfir_serout #(.DATA_W(DATA_W)) u_serout (
        .clk       (clk),
        .rst       (rst),
        .load      (word_mark_in),
        .prod_word (prod_word),
        .bit_out   (prod_bit),
        .mark_out  (word_mark_out)
    );

    assign prod_n = ~prod_bit;

endmodule

// File: tb/symfir_tap_slice_bench.sv
`timescale 1ns/1ps
module symfir_tap_slice_bench;
    localparam int N = 12;

    logic clk = 1'b0;
    logic rst;
    logic word_mark_in;
    logic pair_lo_n;
    logic pair_hi_n;
    logic wgt_n;
    logic prod_n;
    logic word_mark_out;

    int n_chk  = 0;
    int n_fail = 0;

    logic [N-1:0] exp_q[$];
    string        tag_q[$];

    always #4 clk = ~clk;

    symfir_tap_slice #(.DATA_W(N), .WGT_W(10), .WGT_FRAC(8)) u_symfir_tap_slice (
        .clk           (clk),
        .rst           (rst),
        .word_mark_in  (word_mark_in),
        .pair_lo_n     (pair_lo_n),
        .pair_hi_n     (pair_hi_n),
        .wgt_n         (wgt_n),
        .prod_n        (prod_n),
        .word_mark_out (word_mark_out)
    );

    task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    function automatic logic [N-1:0] model(input int a, input int b, input logic [N-1:0] cw);
        logic signed [9:0] c;
        longint s;
        longint p;
        c = cw[9:0];
        s = longint'(a) + longint'(b);
        p = (s * longint'(c)) >>> 8;
        return p[N-1:0];
    endfunction

    // driver: pushes the expected product, then sends one word
    task automatic send(input int a, input int b, input logic [N-1:0] cw,
                        input bit keep, input string tag);
        logic [N-1:0] av;
        logic [N-1:0] bv;
        av = a[N-1:0];
        bv = b[N-1:0];
        if (keep) begin
            exp_q.push_back(model(a, b, cw));
            tag_q.push_back(tag);
        end
        for (int j = 0; j < N; j++) begin
            @(posedge clk);
            #1;
            word_mark_in = (j == 0);
            pair_lo_n    = ~av[j];
            pair_hi_n    = ~bv[j];
            wgt_n        = ~cw[j];
        end
    endtask

    // monitor: collects serial words and compares with the scoreboard
    logic [N-1:0] got_w;
    int           idx;
    bit           active;
    logic         prev_mark;

    always @(negedge clk) begin
        if (rst) begin
            active    = 0;
            idx       = 0;
            prev_mark = 1'b0;
        end else begin
            if (word_mark_out || prev_mark)
                check("R7 mark alignment", {{(N-1){1'b0}}, word_mark_out}, {{(N-1){1'b0}}, prev_mark});
            prev_mark = word_mark_in;
            if (word_mark_out) begin
                active = 1;
                idx    = 0;
            end
            if (active) begin
                got_w[idx] = ~prod_n;
                idx++;
                if (idx == N) begin
                    active = 0;
                    if (exp_q.size() == 0) begin
                        check("R7 unexpected word", got_w, '0);
                    end else begin
                        check(tag_q.pop_front(), got_w, exp_q.pop_front());
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst          = 1'b1;
        word_mark_in = 1'b0;
        pair_lo_n    = 1'b1;
        pair_hi_n    = 1'b1;
        wgt_n        = 1'b1;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 prod_n after reset", {{(N-1){1'b0}}, prod_n}, {{(N-1){1'b0}}, 1'b1});
        check("R1 mark after reset", {{(N-1){1'b0}}, word_mark_out}, '0);

        // two words already in the pipeline at the first mark read as zero
        exp_q.push_back('0); tag_q.push_back("R1 pipeline fill");
        exp_q.push_back('0); tag_q.push_back("R1 pipeline fill");

        send(0,    0,    12'h000, 1, "R2 all pins high");
        send(300,  0,    12'h000, 1, "R2 zero weight");
        send(0,    0,    12'h12C, 1, "R2 zero pair");
        send(100,  50,   12'h100, 1, "R4 unit weight");
        send(3,    0,    12'h3FF, 1, "R4 floor of negative fraction");
        send(200,  -73,  12'h0C3, 1, "R4 fractional weight");
        send(123,  -123, 12'h190, 1, "R4 cancelling pair");
        send(-300, -200, 12'h100, 1, "R3 negative sum");
        send(-1,   -1,   12'h100, 1, "R3 carry out of word");
        send(0,    0,    12'h100, 1, "R3 no carry leak");
        send(511,  511,  12'h1FF, 1, "R5 largest weight");
        send(-512, -512, 12'h201, 1, "R5 most negative sum");
        send(-500, -3,   12'h200, 1, "R5 weight of minus two");
        send(7,    -9,   12'h3DB, 1, "R5 negative by negative");
        send(200,  -73,  12'hCC3, 1, "R6 high weight bits set");
        send(-250, 40,   12'h7E5, 1, "R6 upper bits with negative weight");

        for (int i = 0; i < 20; i++) begin
            int a;
            int b;
            logic [N-1:0] cw;
            a  = ((i * 173) % 1024) - 512;
            b  = ((i * 59 + 300) % 1024) - 512;
            cw = {2'(i % 4), 10'((i * 211 + 7) % 1024)};
            send(a, b, cw, 1, "R8 back-to-back stream");
        end

        send(0, 0, 12'h000, 0, "flush");
        send(0, 0, 12'h000, 0, "flush");
        send(0, 0, 12'h000, 0, "flush");
        @(negedge clk);
        check("R7 all words delivered", N'(exp_q.size()), '0);
        finish_run();
    end

endmodule